// File: doc/BRIEF.md
# DSP Register Load/Store Formatter

This block sits between a 32-bit general load/store bus and a small DSP register file. The file holds plain 32-bit registers and 40-bit accumulators. Each accumulator has a 32-bit body and an 8-bit guard extension. On a load, the block shapes the bus value according to the transfer size, writes it into the selected register and reports the full value it wrote, guard bits included. On a store, it selects the source register and shapes the 32-bit value that goes onto the bus. The guard byte of each accumulator can also be selected as an operand of its own.

Word transfers carry their data in the upper half of a register. A word load places the bus halfword there and clears the lower half. Loading an accumulator body fills its guard byte with copies of the body's sign bit. A guard store spreads the guard's top bit across the upper 24 bus bits. Select codes past the last guard, where the status register would sit, are refused. No transfer has any effect on condition flags, because the block holds none.

Top module: `dsp_ldst_fmt`

## Requirements
- R1: A word load (isLong=0) into a plain register or an accumulator body writes busIn[15:0] into bits 31:16 and zero into bits 15:0.
- R2: A longword load (isLong=1) into a plain register or an accumulator body writes busIn[31:0] unchanged into bits 31:0.
- R3: A load into an accumulator body (regSel 4 or 5) sets its guard byte, wbValue[39:32], to eight copies of bit 31 of the loaded body, for both sizes.
- R4: A load into a guard register (regSel 6 or 7) writes busIn[7:0] into that guard, whatever the size, and leaves the accumulator body unchanged. wbValue is {new guard, old body}.
- R5: A word store from a plain register or an accumulator body drives busOut = {16'h0000, source[31:16]}.
- R6: A longword store from a plain register or an accumulator body drives busOut = source[31:0].
- R7: A store from a guard register drives busOut = {24 copies of guard[7], guard[7:0]}, whatever the size.
- R8: Select codes 8 to 15 (status register and unused codes) are refused. No register changes, wbValid and busOutValid stay 0, and busOut is 0.
- R9: The results are registered once. wbValid, wbSel, wbValue, busOutValid and busOut reflect a transfer strobed with valid in the cycle after it. In any cycle without an accepted transfer, both valid outputs are 0 and busOut is 0.
- R10: A load into a plain register (regSel 0 to 3) reports wbValue[39:32] = 0, since plain registers have no guard bits.
- R11: After reset, every register, including both guards, reads as zero, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| valid | input | 1 | Transfer strobe |
| isStore | input | 1 | 1 = store to bus, 0 = load from bus |
| isLong | input | 1 | 1 = 32-bit longword, 0 = 16-bit word |
| regSel | input | 4 | 0-3 plain, 4-5 accumulator body, 6-7 guard, 8-15 refused |
| busIn | input | 32 | Load data from the bus |
| wbValid | output | 1 | A register was written in the previous cycle |
| wbSel | output | 4 | Register that was written |
| wbValue | output | 40 | Value written: guard byte in 39:32, body in 31:0 |
| busOutValid | output | 1 | busOut carries store data |
| busOut | output | 32 | Store data for the bus |

## Verification
A corrupted register body or guard stays hidden until a store reads it back. A guard-only load also exposes it, because wbValue reports the old body next to the new guard. The bench therefore follows every kind of load with stores of the same register and of its guard. A fault then shows on busOut one cycle after the store strobe. A decode or placement fault, such as a wrong half, a missing clear or wrong sign fill, shows on wbValue in the cycle right after the load.

// File: rtl/dsp_ldst_pkg.sv
package dsp_ldst_pkg;
  localparam int BUS_W  = 32;
  localparam int HALF_W = BUS_W / 2;
  localparam int GRD_W  = 8;
  localparam int ACC_W  = BUS_W + GRD_W;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic wrPlain;
    logic wrBody;
    logic wrGuard;
    logic rdPlain;
    logic rdBody;
    logic rdGuard;
    logic isLong;
  } fmtStrobe_t;
endpackage

// File: rtl/dsp_ldst_ctrl.sv
module dsp_ldst_ctrl
  import dsp_ldst_pkg::*;
#(
  parameter int NUM_PLAIN = 4,
  parameter int NUM_ACC   = 2,
  parameter int SEL_W     = 4,
  parameter int IDX_W     = 2
) (
  input  logic             valid,
  input  logic             isStore,
  input  logic             isLong,
  input  logic [SEL_W-1:0] regSel,
  output fmtStrobe_t       strobe,
  output logic [IDX_W-1:0] idx
);
  localparam logic [SEL_W-1:0] ACC_BASE = SEL_W'(NUM_PLAIN);
  localparam logic [SEL_W-1:0] GRD_BASE = SEL_W'(NUM_PLAIN + NUM_ACC);
  localparam logic [SEL_W-1:0] SEL_END  = SEL_W'(NUM_PLAIN + 2 * NUM_ACC);

  logic [SEL_W-1:0] offs;
  logic isLoad, doStore;

  assign isLoad  = valid && !isStore;
  assign doStore = valid && isStore;

  always_comb begin
    strobe        = '0;
    strobe.isLong = isLong;
    offs          = '0;
    if (regSel < ACC_BASE) begin
      strobe.wrPlain = isLoad;
      strobe.rdPlain = doStore;
      offs           = regSel;
    end else if (regSel < GRD_BASE) begin
      strobe.wrBody = isLoad;
      strobe.rdBody = doStore;
      offs          = regSel - ACC_BASE;
    end else if (regSel < SEL_END) begin
      strobe.wrGuard = isLoad;
      strobe.rdGuard = doStore;
      offs           = regSel - GRD_BASE;
    end
  end

  assign idx = offs[IDX_W-1:0];
endmodule

// File: rtl/dsp_ldst_dp.sv
module dsp_ldst_dp
  import dsp_ldst_pkg::*;
#(
  parameter int NUM_PLAIN = 4,
  parameter int NUM_ACC   = 2,
  parameter int SEL_W     = 4,
  parameter int IDX_W     = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  fmtStrobe_t       strobe,
  input  logic [IDX_W-1:0] idx,
  input  logic [SEL_W-1:0] regSel,
  input  logic [BUS_W-1:0] busIn,
  output logic             wbValid,
  output logic [SEL_W-1:0] wbSel,
  output logic [ACC_W-1:0] wbValue,
  output logic             busOutValid,
  output logic [BUS_W-1:0] busOut
);
  logic [BUS_W-1:0] plainQ [NUM_PLAIN];
  logic [BUS_W-1:0] bodyQ  [NUM_ACC];
  logic [GRD_W-1:0] guardQ [NUM_ACC];

  logic [BUS_W-1:0] loadBody, curPlain, curBody, srcBody, storeWord;
  logic [GRD_W-1:0] curGuard;
  logic [ACC_W-1:0] nextWb;
  logic             anyWr, anyRd;

  // Size placement: a word lands in the upper half, lower half cleared
  assign loadBody = strobe.isLong ? busIn : {busIn[HALF_W-1:0], {HALF_W{1'b0}}};

  always_comb begin
    curPlain = '0;
    for (int i = 0; i < NUM_PLAIN; i++)
      if (idx == IDX_W'(i)) curPlain = plainQ[i];
    curBody  = '0;
    curGuard = '0;
    for (int i = 0; i < NUM_ACC; i++)
      if (idx == IDX_W'(i)) begin
        curBody  = bodyQ[i];
        curGuard = guardQ[i];
      end
  end

  assign srcBody = strobe.rdPlain ? curPlain : curBody;

  always_comb begin
    if (strobe.rdGuard)
      storeWord = {{(BUS_W-GRD_W){curGuard[GRD_W-1]}}, curGuard};
    else if (strobe.isLong)
      storeWord = srcBody;
    else
      storeWord = {{HALF_W{1'b0}}, srcBody[BUS_W-1:HALF_W]};
  end

  always_comb begin
    nextWb = '0;
    if (strobe.wrPlain)      nextWb = {{GRD_W{1'b0}}, loadBody};
    else if (strobe.wrBody)  nextWb = {{GRD_W{loadBody[BUS_W-1]}}, loadBody};
    else if (strobe.wrGuard) nextWb = {busIn[GRD_W-1:0], curBody};
  end

  assign anyWr = strobe.wrPlain || strobe.wrBody || strobe.wrGuard;
  assign anyRd = strobe.rdPlain || strobe.rdBody || strobe.rdGuard;

  for (genvar gi = 0; gi < NUM_PLAIN; gi++) begin : g_plain
    logic [BUS_W-1:0] r;
    always_ff @(posedge clk or negedge rstN)
      if (!rstN) r <= '0;
      else if (strobe.wrPlain && idx == IDX_W'(gi)) r <= loadBody;
    assign plainQ[gi] = r;
  end

  for (genvar gi = 0; gi < NUM_ACC; gi++) begin : g_acc
    logic [BUS_W-1:0] body;
    logic [GRD_W-1:0] grd;
    always_ff @(posedge clk or negedge rstN)
      if (!rstN) begin
        body <= '0;
        grd  <= '0;
      end else if (idx == IDX_W'(gi)) begin
        if (strobe.wrBody) begin
          body <= loadBody;
          grd  <= {GRD_W{loadBody[BUS_W-1]}};
        end else if (strobe.wrGuard) begin
          grd <= busIn[GRD_W-1:0];
        end
      end
    assign bodyQ[gi]  = body;
    assign guardQ[gi] = grd;
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      wbValid     <= 1'b0;
      wbSel       <= '0;
      wbValue     <= '0;
      busOutValid <= 1'b0;
      busOut      <= '0;
    end else begin
      wbValid     <= anyWr;
      busOutValid <= anyRd;
      busOut      <= anyRd ? storeWord : '0;
      if (anyWr) begin
        wbSel   <= regSel;
        wbValue <= nextWb;
      end
    end
endmodule

// File: rtl/dsp_ldst_fmt.sv
module dsp_ldst_fmt
  import dsp_ldst_pkg::*;
#(
  parameter int NUM_PLAIN = 4,
  parameter int NUM_ACC   = 2,
  parameter int SEL_W     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             valid,
  input  logic             isStore,
  input  logic             isLong,
  input  logic [SEL_W-1:0] regSel,
  input  logic [31:0]      busIn,
  output logic             wbValid,
  output logic [SEL_W-1:0] wbSel,
  output logic [39:0]      wbValue,
  output logic             busOutValid,
  output logic [31:0]      busOut
);
  localparam int MAXN  = (NUM_PLAIN > NUM_ACC) ? NUM_PLAIN : NUM_ACC;
  localparam int IDX_W = (MAXN < 2) ? 1 : $clog2(MAXN);

  fmtStrobe_t       strobe;
  logic [IDX_W-1:0] idx;

  dsp_ldst_ctrl #(
    .NUM_PLAIN(NUM_PLAIN), .NUM_ACC(NUM_ACC), .SEL_W(SEL_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .valid(valid), .isStore(isStore), .isLong(isLong), .regSel(regSel),
    .strobe(strobe), .idx(idx)
  );

  dsp_ldst_dp #(
    .NUM_PLAIN(NUM_PLAIN), .NUM_ACC(NUM_ACC), .SEL_W(SEL_W), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .idx(idx), .regSel(regSel),
    .busIn(busIn), .wbValid(wbValid), .wbSel(wbSel), .wbValue(wbValue),
    .busOutValid(busOutValid), .busOut(busOut)
  );
endmodule

// File: rtl/dsp_ldst_fmt_chk.sv
module dsp_ldst_fmt_chk #(
  parameter int NUM_PLAIN = 4,
  parameter int NUM_ACC   = 2,
  parameter int SEL_W     = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             valid,
  input logic             isStore,
  input logic             isLong,
  input logic [SEL_W-1:0] regSel,
  input logic [31:0]      busIn,
  input logic             wbValid,
  input logic [SEL_W-1:0] wbSel,
  input logic [39:0]      wbValue,
  input logic             busOutValid,
  input logic [31:0]      busOut
);
  localparam logic [SEL_W-1:0] ACC_BASE = SEL_W'(NUM_PLAIN);
  localparam logic [SEL_W-1:0] GRD_BASE = SEL_W'(NUM_PLAIN + NUM_ACC);
  localparam logic [SEL_W-1:0] SEL_END  = SEL_W'(NUM_PLAIN + 2 * NUM_ACC);

  p_word_low_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    (valid && !isStore && !isLong && regSel < GRD_BASE) |=> (wbValid && wbValue[15:0] == 16'h0));

  p_long_body_r2: assert property (@(posedge clk) disable iff (!rstN)
    (valid && !isStore && isLong && regSel < GRD_BASE) |=> (wbValue[31:0] == $past(busIn)));

  p_guard_sign_r3: assert property (@(posedge clk) disable iff (!rstN)
    (valid && !isStore && regSel >= ACC_BASE && regSel < GRD_BASE)
      |=> (wbValue[39:32] == {8{wbValue[31]}}));

  p_guard_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    (valid && !isStore && regSel >= GRD_BASE && regSel < SEL_END)
      |=> (wbValue[39:32] == $past(busIn[7:0])));

  p_guard_store_r7: assert property (@(posedge clk) disable iff (!rstN)
    (valid && isStore && regSel >= GRD_BASE && regSel < SEL_END)
      |=> (busOutValid && busOut[31:8] == {24{busOut[7]}}));

  p_word_store_r5: assert property (@(posedge clk) disable iff (!rstN)
    (valid && isStore && !isLong && regSel < GRD_BASE) |=> (busOut[31:16] == 16'h0));

  p_refused_r8: assert property (@(posedge clk) disable iff (!rstN)
    (valid && regSel >= SEL_END) |=> (!wbValid && !busOutValid && busOut == 32'h0));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !valid |=> (!wbValid && !busOutValid));

  p_wb_sel_r9: assert property (@(posedge clk) disable iff (!rstN)
    (valid && !isStore && regSel < SEL_END) |=> (wbValid && wbSel == $past(regSel)));

  p_plain_no_guard_r10: assert property (@(posedge clk) disable iff (!rstN)
    (valid && !isStore && regSel < ACC_BASE) |=> (wbValue[39:32] == 8'h0));
endmodule

bind dsp_ldst_fmt dsp_ldst_fmt_chk #(
  .NUM_PLAIN(NUM_PLAIN), .NUM_ACC(NUM_ACC), .SEL_W(SEL_W)
) u_chk (.*);

// File: tb/dsp_ldst_fmt_tb.sv
module dsp_ldst_fmt_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        valid = 1'b0, isStore = 1'b0, isLong = 1'b0;
  logic [3:0]  regSel = '0;
  logic [31:0] busIn = '0;
  logic        wbValid, busOutValid;
  logic [3:0]  wbSel;
  logic [39:0] wbValue;
  logic [31:0] busOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsp_ldst_fmt u_dut (
    .clk(clk), .rstN(rstN), .valid(valid), .isStore(isStore), .isLong(isLong),
    .regSel(regSel), .busIn(busIn), .wbValid(wbValid), .wbSel(wbSel),
    .wbValue(wbValue), .busOutValid(busOutValid), .busOut(busOut)
  );

  typedef struct {
    bit          expWb;
    logic [3:0]  sel;
    logic [39:0] val;
    bit          expBo;
    logic [31:0] bo;
    string       tag;
  } item_t;

  item_t       sbq[$];
  int          nVec = 0, nFail = 0;
  bit          doneFlag = 0;
  logic [31:0] mPlain [4];
  logic [31:0] mBody  [2];
  logic [7:0]  mGuard [2];

  // Bench model built from the requirements, one transfer per cycle
  task automatic drive(bit st, bit lg, logic [3:0] sel, logic [31:0] d, string tag);
    item_t it;
    logic [31:0] v, src;
    int a;
    it.expWb = 0; it.expBo = 0; it.sel = sel; it.val = '0; it.bo = '0; it.tag = tag;
    v = lg ? d : {d[15:0], 16'h0};
    if (sel < 6) begin
      a = (sel < 4) ? int'(sel) : int'(sel) - 4;
      if (!st) begin
        it.expWb = 1;
        if (sel < 4) begin mPlain[a] = v; it.val = {8'h0, v}; end
        else begin mBody[a] = v; mGuard[a] = {8{v[31]}}; it.val = {mGuard[a], v}; end
      end else begin
        it.expBo = 1;
        src = (sel < 4) ? mPlain[a] : mBody[a];
        it.bo = lg ? src : {16'h0, src[31:16]};
      end
    end else if (sel < 8) begin
      a = int'(sel) - 6;
      if (!st) begin
        it.expWb = 1; mGuard[a] = d[7:0]; it.val = {d[7:0], mBody[a]};
      end else begin
        it.expBo = 1; it.bo = {{24{mGuard[a][7]}}, mGuard[a]};
      end
    end
    @(negedge clk);
    valid = 1; isStore = st; isLong = lg; regSel = sel; busIn = d;
    sbq.push_back(it);
  endtask

  task automatic idle(string tag);
    item_t it;
    it.expWb = 0; it.expBo = 0; it.sel = '0; it.val = '0; it.bo = '0; it.tag = tag;
    @(negedge clk);
    valid = 0; isStore = 0; isLong = 0; regSel = '0; busIn = 32'hDEAD_BEEF;
    sbq.push_back(it);
  endtask

  // Monitor: results appear after the edge that samples the strobe
  initial begin
    forever begin
      @(posedge clk); #1;
      if (sbq.size() > 0) begin
        item_t e;
        bit bad;
        e = sbq.pop_front();
        nVec++;
        bad = (wbValid !== e.expWb) || (busOutValid !== e.expBo)
           || (e.expWb && (wbSel !== e.sel || wbValue !== e.val))
           || (busOut !== e.bo);
        if (bad) begin
          nFail++;
          $display("FAIL %s: wbV=%0b sel=%0d wb=%010h boV=%0b bo=%08h | exp wbV=%0b sel=%0d wb=%010h boV=%0b bo=%08h",
                   e.tag, wbValid, wbSel, wbValue, busOutValid, busOut,
                   e.expWb, e.sel, e.val, e.expBo, e.bo);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!doneFlag) begin
      nFail++;
      $display("FAIL watchdog: run did not finish, actual hung, expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) mPlain[i] = '0;
    for (int i = 0; i < 2; i++) begin mBody[i] = '0; mGuard[i] = '0; end
    repeat (3) @(negedge clk);
    // R11: outputs after reset
    nVec++;
    if (wbValid !== 0 || busOutValid !== 0 || busOut !== 0 || wbValue !== 0) begin
      nFail++;
      $display("FAIL R11: outputs wbV=%0b boV=%0b bo=%08h wb=%010h, expected all zero",
               wbValid, busOutValid, busOut, wbValue);
    end
    rstN = 1;
    // R11: every register reads zero after reset
    for (int s = 0; s < 8; s++) drive(1, 1, 4'(s), 32'h0, "R11 reset readback");
    idle("R9 idle");
    // R1 / R10: word loads into plain registers
    drive(0, 0, 4'd0, 32'hABCD_1234, "R1 word load plain");
    drive(0, 0, 4'd3, 32'h0000_8001, "R10 plain word no guard");
    // R2: longword load
    drive(0, 1, 4'd1, 32'hF00D_CAFE, "R2 long load plain");
    drive(1, 1, 4'd1, 32'h0, "R6 long store plain");
    drive(1, 0, 4'd1, 32'h0, "R5 word store plain");
    drive(1, 1, 4'd0, 32'h0, "R1 lower half cleared");
    // R3: accumulator loads with sign fill
    drive(0, 0, 4'd4, 32'h1111_8000, "R3 word load acc negative");
    drive(1, 0, 4'd6, 32'h0, "R7 guard store negative");
    drive(0, 1, 4'd5, 32'h7FFF_FFFF, "R3 long load acc positive");
    drive(1, 0, 4'd7, 32'h0, "R7 guard store positive");
    drive(0, 1, 4'd5, 32'h8000_0000, "R3 long load acc negative");
    // R4: guard-only loads keep the body
    drive(0, 0, 4'd6, 32'hFFFF_FF5A, "R4 guard load size word");
    drive(0, 1, 4'd7, 32'h1234_56A5, "R4 guard load size long");
    drive(1, 1, 4'd5, 32'h0, "R4 body unchanged after guard load");
    drive(1, 0, 4'd7, 32'h0, "R7 guard store word size");
    drive(1, 1, 4'd6, 32'h0, "R7 guard store long size");
    drive(1, 0, 4'd4, 32'h0, "R5 word store acc");
    // R8: refused selects, then proof nothing changed
    drive(0, 1, 4'd8, 32'hFFFF_FFFF, "R8 refused load");
    drive(1, 1, 4'd15, 32'h0, "R8 refused store");
    drive(0, 0, 4'd12, 32'h1234_5678, "R8 refused word load");
    for (int s = 0; s < 8; s++) drive(1, 1, 4'(s), 32'h0, "R8 state unchanged");
    idle("R9 idle after store");
    drive(0, 1, 4'd2, 32'h5555_AAAA, "R9 back to back");
    idle("R9 gap");
    // Mixed traffic
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 4'd15) idle("R9 random idle");
      else drive(r[4], r[5], {r[9], r[8:6] == 3'd7 ? 1'b0 : 1'b0, r[7:6]} % 4'd10, $urandom, "R1-R8 mixed");
    end
    idle("R9 drain");
    repeat (3) @(negedge clk);
    doneFlag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end
endmodule